// File: doc/BRIEF.md
# Banked Serial-Controller Register File

This block is the host-side register file of a PC-style serial controller. A host reaches eight byte-wide registers through a 3-bit offset, with separate read and write strobes. Read data is registered and is valid in the cycle after the read strobe. The transmit shifter, the receive shifter, the baud generator and the FIFO storage are outside the block. They connect through simple hooks:

- a receive-valid pulse carrying the received byte;
- a one-cycle transmit-load pulse carrying the byte to send;
- a transmit-ready input;
- a transmitter-idle input.

The register map is banked. Line-control bit 7 opens the divisor bank: offsets 0 and 1 then reach the 16-bit baud divisor instead of the data and interrupt-enable registers. Loading line control with exactly 0xBF opens the extended bank. In that bank, offset 2 reaches a hidden feature register that holds the automatic CTS/RTS enables, and the scratch register is hidden. FIFO-control writes are reported back through the identification register.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control, modem control, interrupt enable, scratch, divisor and feature registers read 0x00. Line status reads 0x60 (bits 5 and 6 set). Identification reads 0x01.
- R2: With line control 0x03, offsets 1, 3, 4 and 7 read back the last value written. Offset 6 returns the modem-status input. Writes to offset 5 are ignored.
- R3: While line-control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes, which appear on `divisor`. While bit 7 is 0, divisor writes do not reach interrupt enable, and interrupt-enable or data writes leave `divisor` unchanged.
- R4: While line control equals 0xBF, offset 2 reads and writes the feature register. Scratch reads return 0x00 and scratch writes are ignored. Any other line-control value restores normal decoding and the old scratch value.
- R5: Feature-register bit 7 drives `auto_cts` and bit 6 drives `auto_rts`, so writing 0xC0 sets both.
- R6: A write to offset 2 outside the extended bank sets `fifo_enable` from data bit 0. Data bits 1 and 2 each give a one-cycle `rx_fifo_clr` or `tx_fifo_clr` pulse in the cycle after the write. Data bit 5 updates `fifo_deep` only while line-control bit 7 is 1.
- R7: Identification reads 0x01 with FIFOs disabled, 0xC1 with FIFOs enabled, and 0xE1 with FIFOs enabled in deep mode.
- R8: A `rx_valid` pulse stores `rx_byte` and sets line-status bit 0. A read of offset 0 with bit 7 of line control clear returns the byte and clears bit 0.
- R9: A write of offset 0 with bit 7 of line control clear raises `tx_load` for one cycle, in the cycle after the write, with the byte on `tx_byte`. It also clears line-status bit 5 until `tx_ready` is seen high.
- R10: Line-status bit 6 equals `tx_idle` as sampled at the previous clock edge.
- R11: Modem control reads back all bits as written, including bit 5. `modem_ctrl` and `line_ctrl` show the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmit side accepted the byte |
| tx_idle | input | 1 | Transmitter fully idle |
| tx_load | output | 1 | One-cycle transmit load pulse |
| tx_byte | output | 8 | Byte to transmit |
| modem_status_in | input | 8 | Modem status value |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 8 | Modem control register |
| auto_cts | output | 1 | Automatic CTS flow enable |
| auto_rts | output | 1 | Automatic RTS flow enable |
| fifo_enable | output | 1 | FIFOs enabled |
| fifo_deep | output | 1 | Deep FIFO mode selected |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |

## Verification
The checker watches the following on every cycle:

- every `tx_load` and FIFO-clear pulse traces back to the write that caused it;
- `divisor` stays frozen under writes made while the divisor bank is closed;
- the idle bit tracks its input;
- a receive pulse always leaves data-ready set.

Bank switching is a matter of sequence, so only the bench's scenarios can show it. This covers the extended bank hiding and then restoring scratch, and divisor bytes not leaking into interrupt enable. The same holds for the readback of the identification bits after each FIFO setting, and for the set and clear order of data-ready and holding-empty.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDF  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LST  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MST  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_IEN,
    SEL_IDF,
    SEL_LCTL,
    SEL_MCTL,
    SEL_LST,
    SEL_MST,
    SEL_SCR,
    SEL_DIV_LO,
    SEL_DIV_HI,
    SEL_FEAT
  } reg_sel_e;
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXT_KEY = 8'hBF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lctl,
  output reg_sel_e          sel
);
  logic div_open;
  logic ext_open;

  assign div_open = lctl[DATA_W-1];
  assign ext_open = (lctl == EXT_KEY);

  always_comb begin
    sel = SEL_NONE;
    unique case (addr)
      OFS_DATA: sel = div_open ? SEL_DIV_LO : SEL_DATA;
      OFS_IEN:  sel = div_open ? SEL_DIV_HI : SEL_IEN;
      OFS_IDF:  sel = ext_open ? SEL_FEAT   : SEL_IDF;
      OFS_LCTL: sel = SEL_LCTL;
      OFS_MCTL: sel = SEL_MCTL;
      OFS_LST:  sel = SEL_LST;
      OFS_MST:  sel = SEL_MST;
      OFS_SCR:  sel = ext_open ? SEL_NONE   : SEL_SCR;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rbr_read,
  input  logic              thr_write,
  input  logic [DATA_W-1:0] thr_data,
  input  logic              tx_ready,
  input  logic              tx_idle,
  output logic [DATA_W-1:0] rbr_q,
  output logic [DATA_W-1:0] lst_q,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte
);
  logic data_rdy;
  logic hold_empty;
  logic shift_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_rdy   <= 1'b0;
      hold_empty <= 1'b1;
      shift_idle <= 1'b1;
      rbr_q      <= '0;
      tx_load    <= 1'b0;
      tx_byte    <= '0;
    end else begin
      shift_idle <= tx_idle;
      tx_load    <= thr_write;
      if (thr_write) begin
        tx_byte    <= thr_data;
        hold_empty <= 1'b0;
      end else if (tx_ready) begin
        hold_empty <= 1'b1;
      end
      if (rx_valid) begin
        rbr_q    <= rx_byte;
        data_rdy <= 1'b1;
      end else if (rbr_read) begin
        data_rdy <= 1'b0;
      end
    end
  end

  always_comb begin
    lst_q    = '0;
    lst_q[0] = data_rdy;
    lst_q[5] = hold_empty;
    lst_q[6] = shift_idle;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXT_KEY = 8'hBF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                rx_valid,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic                tx_ready,
  input  logic                tx_idle,
  output logic                tx_load,
  output logic [DATA_W-1:0]   tx_byte,
  input  logic [DATA_W-1:0]   modem_status_in,
  output logic [2*DATA_W-1:0] divisor,
  output logic [DATA_W-1:0]   line_ctrl,
  output logic [DATA_W-1:0]   modem_ctrl,
  output logic                auto_cts,
  output logic                auto_rts,
  output logic                fifo_enable,
  output logic                fifo_deep,
  output logic                rx_fifo_clr,
  output logic                tx_fifo_clr
);
  localparam int DIV_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic [DATA_W-1:0] ien_q, lctl_q, mctl_q, scr_q, dlo_q, dhi_q, feat_q;
  logic [DATA_W-1:0] rbr_q, lst_q, idf_val, rd_mux;
  logic              fen_q, fdeep_q;

  uart_addr_decode #(.DATA_W(DATA_W), .EXT_KEY(EXT_KEY)) u_dec (
    .addr (reg_addr),
    .lctl (lctl_q),
    .sel  (sel)
  );

  uart_line_status #(.DATA_W(DATA_W)) u_lst (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rbr_read  (rd_en && sel == SEL_DATA),
    .thr_write (wr_en && sel == SEL_DATA),
    .thr_data  (wr_data),
    .tx_ready  (tx_ready),
    .tx_idle   (tx_idle),
    .rbr_q     (rbr_q),
    .lst_q     (lst_q),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q       <= '0;
      lctl_q      <= '0;
      mctl_q      <= '0;
      scr_q       <= '0;
      dlo_q       <= '0;
      dhi_q       <= '0;
      feat_q      <= '0;
      fen_q       <= 1'b0;
      fdeep_q     <= 1'b0;
      rx_fifo_clr <= 1'b0;
      tx_fifo_clr <= 1'b0;
    end else begin
      rx_fifo_clr <= 1'b0;
      tx_fifo_clr <= 1'b0;
      if (wr_en) begin
        unique case (sel)
          SEL_IEN:    ien_q  <= wr_data;
          SEL_LCTL:   lctl_q <= wr_data;
          SEL_MCTL:   mctl_q <= wr_data;
          SEL_SCR:    scr_q  <= wr_data;
          SEL_DIV_LO: dlo_q  <= wr_data;
          SEL_DIV_HI: dhi_q  <= wr_data;
          SEL_FEAT:   feat_q <= wr_data;
          SEL_IDF: begin
            fen_q       <= wr_data[0];
            rx_fifo_clr <= wr_data[1];
            tx_fifo_clr <= wr_data[2];
            if (lctl_q[DATA_W-1]) fdeep_q <= wr_data[5];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    idf_val    = '0;
    idf_val[0] = 1'b1;
    idf_val[7] = fen_q;
    idf_val[6] = fen_q;
    idf_val[5] = fen_q & fdeep_q;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:   rd_mux = rbr_q;
      SEL_IEN:    rd_mux = ien_q;
      SEL_IDF:    rd_mux = idf_val;
      SEL_LCTL:   rd_mux = lctl_q;
      SEL_MCTL:   rd_mux = mctl_q;
      SEL_LST:    rd_mux = lst_q;
      SEL_MST:    rd_mux = modem_status_in;
      SEL_SCR:    rd_mux = scr_q;
      SEL_DIV_LO: rd_mux = dlo_q;
      SEL_DIV_HI: rd_mux = dhi_q;
      SEL_FEAT:   rd_mux = feat_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign divisor     = {dhi_q, dlo_q};
  assign line_ctrl   = lctl_q;
  assign modem_ctrl  = mctl_q;
  assign auto_cts    = feat_q[7];
  assign auto_rts    = feat_q[6];
  assign fifo_enable = fen_q;
  assign fifo_deep   = fdeep_q;

  logic [DIV_W-1:0] unused_div_w;
  assign unused_div_w = divisor;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        reg_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rx_valid,
  input logic              tx_idle,
  input logic              tx_load,
  input logic [2*DATA_W-1:0] divisor,
  input logic [DATA_W-1:0] line_ctrl,
  input logic              rx_fifo_clr,
  input logic              tx_fifo_clr,
  input logic [DATA_W-1:0] lst_q
);
  p_tx_load_cause_r9: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> ($past(wr_en) && $past(reg_addr) == 3'd0 && !$past(line_ctrl[DATA_W-1])));

  p_rx_clr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_clr |-> ($past(wr_en) && $past(reg_addr) == 3'd2 && $past(wr_data[1])));

  p_tx_clr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_clr |-> ($past(wr_en) && $past(reg_addr) == 3'd2 && $past(wr_data[2])));

  p_div_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !line_ctrl[DATA_W-1]) |=> $stable(divisor));

  p_idle_track_r10: assert property (@(posedge clk) disable iff (rst)
    tx_idle |=> lst_q[6]);

  p_rx_sets_ready_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> lst_q[0]);
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_addr    (reg_addr),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rx_valid    (rx_valid),
  .tx_idle     (tx_idle),
  .tx_load     (tx_load),
  .divisor     (divisor),
  .line_ctrl   (line_ctrl),
  .rx_fifo_clr (rx_fifo_clr),
  .tx_fifo_clr (tx_fifo_clr),
  .lst_q       (lst_q)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rx_valid = 1'b0, tx_ready = 1'b0, tx_idle = 1'b1;
  logic [7:0]  rx_byte = '0;
  logic        tx_load;
  logic [7:0]  tx_byte;
  logic [7:0]  modem_status_in = 8'h96;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl, modem_ctrl;
  logic        auto_cts, auto_rts, fifo_enable, fifo_deep, rx_fifo_clr, tx_fifo_clr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_regbank uut (.*);

  function automatic logic [7:0] exp_ident(input logic fe, input logic deep);
    return {fe, fe, fe & deep, 4'b0000, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, {8'h00, v}, {8'h00, exp});
  endtask

  initial begin
    #300000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] m_ien, m_mctl, m_scr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 lsr", 3'd5, 8'h60);
    rd_chk("R1 ident", 3'd2, 8'h01);
    rd_chk("R1 lctl", 3'd3, 8'h00);
    rd_chk("R1 mctl", 3'd4, 8'h00);
    rd_chk("R1 ien", 3'd1, 8'h00);
    rd_chk("R1 scr", 3'd7, 8'h00);
    check("R1 divisor", divisor, 16'h0000);

    // R3 divisor bank
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    check("R3 divisor port", divisor, 16'h1234);
    rd_chk("R3 div hi read", 3'd1, 8'h12);
    rd_chk("R3 div lo read", 3'd0, 8'h34);
    wr(3'd3, 8'h03);
    rd_chk("R3 ien isolated", 3'd1, 8'h00);
    check("R11 line_ctrl", {8'h00, line_ctrl}, 16'h0003);
    wr(3'd1, 8'h0F);
    check("R3 divisor kept", divisor, 16'h1234);

    // R6/R7 FIFO control
    wr(3'd2, 8'h27);
    check("R6 rx clr pulse", {15'd0, rx_fifo_clr}, 16'd1);
    check("R6 tx clr pulse", {15'd0, tx_fifo_clr}, 16'd1);
    check("R6 deep locked", {15'd0, fifo_deep}, 16'd0);
    @(negedge clk);
    check("R6 clr one cycle", {14'd0, rx_fifo_clr, tx_fifo_clr}, 16'd0);
    rd_chk("R7 ident fifo", 3'd2, exp_ident(1'b1, 1'b0));
    wr(3'd3, 8'h80);
    wr(3'd2, 8'h27);
    check("R6 deep set", {15'd0, fifo_deep}, 16'd1);
    rd_chk("R7 ident deep", 3'd2, exp_ident(1'b1, 1'b1));
    wr(3'd3, 8'h03);
    wr(3'd2, 8'h00);
    check("R6 fifo off", {15'd0, fifo_enable}, 16'd0);
    rd_chk("R7 ident off", 3'd2, exp_ident(1'b0, 1'b1));

    // R4/R5 extended bank
    wr(3'd7, 8'h5A);
    wr(3'd3, 8'hBF);
    rd_chk("R4 scr hidden", 3'd7, 8'h00);
    wr(3'd2, 8'hC0);
    check("R5 auto flow", {14'd0, auto_cts, auto_rts}, 16'd3);
    rd_chk("R4 feat read", 3'd2, 8'hC0);
    check("R4 no fifo write", {15'd0, fifo_enable}, 16'd0);
    wr(3'd7, 8'h11);
    wr(3'd3, 8'h03);
    rd_chk("R4 scr restored", 3'd7, 8'h5A);
    rd_chk("R4 ident restored", 3'd2, 8'h01);

    // R8 receive path
    rx_byte = 8'hA5; rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    rd_chk("R8 ready set", 3'd5, 8'h61);
    rd_chk("R8 data", 3'd0, 8'hA5);
    rd_chk("R8 ready clr", 3'd5, 8'h60);

    // R9 transmit path
    wr(3'd0, 8'h3C);
    check("R9 load", {7'd0, tx_load, tx_byte}, {7'd0, 1'b1, 8'h3C});
    @(negedge clk);
    check("R9 load pulse", {15'd0, tx_load}, 16'd0);
    rd_chk("R9 holding busy", 3'd5, 8'h40);
    tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
    rd_chk("R9 holding empty", 3'd5, 8'h60);

    // R10 idle bit
    tx_idle = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_chk("R10 busy", 3'd5, 8'h20);
    tx_idle = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_chk("R10 idle", 3'd5, 8'h60);

    // R11 / R2
    wr(3'd4, 8'h23);
    rd_chk("R11 mctl bit5", 3'd4, 8'h23);
    check("R11 modem_ctrl", {8'h00, modem_ctrl}, 16'h0023);
    wr(3'd5, 8'h00);
    rd_chk("R2 lsr ignores write", 3'd5, 8'h60);
    rd_chk("R2 msr input", 3'd6, 8'h96);

    // R2 random register traffic
    begin
      int unused_seed;
      unused_seed = $urandom(32'd1234);
    end
    m_ien = 8'h0F; m_mctl = 8'h23; m_scr = 8'h5A;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] d;
      int op;
      d = 8'($urandom);
      op = int'($urandom % 6);
      case (op)
        0: begin wr(3'd1, d); m_ien = d; end
        1: begin wr(3'd4, d); m_mctl = d; end
        2: begin wr(3'd7, d); m_scr = d; end
        3: rd_chk("R2 ien", 3'd1, m_ien);
        4: rd_chk("R11 mctl", 3'd4, m_mctl);
        default: rd_chk("R2 scr", 3'd7, m_scr);
      endcase
    end
    check("R3 divisor after traffic", divisor, 16'h1234);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule